// File: doc/BRIEF.md
# Dual-Channel Serial Wiper Register Interface

This block is the digital control front end of a two-channel, 256-step digitally controlled resistor. A host writes to it over a three-wire serial link made of an active-low select, a serial clock and a data line. There is no readback path. The block samples these pins with a faster system clock. It shifts in a nine-bit word and keeps only the last nine bits of each frame. When the select line is released, it commits the word to one of two wiper code registers.

The most significant bit of the word is a channel address and the remaining eight bits are the wiper code. The code maps linearly onto the ladder taps. Code 0 sits at the low end and the all-ones code sits one step short of the high end. Both codes come out in parallel, and each channel has a one-cycle strobe that marks a fresh value. Both registers start at midscale so that the resistor sits in a neutral position after reset.

Top module: `spi_wiper_ctrl`

## Requirements
- R1: After reset both wiper outputs read 0x80 (midscale) and both load strobes are low.
- R2: A frame is sent most significant bit first, one bit per rising serial clock edge while select is low. Of the nine-bit word, bit 8 is the channel address and bits 7..0 are the wiper code. The code is committed when select returns high.
- R3: Address 0 writes wiper0 and address 1 writes wiper1. The register that is not addressed keeps its value.
- R4: When a frame carries more than nine clock edges, the earlier bits are dropped and the last nine edges form the word.
- R5: A frame with fewer than nine rising clock edges between select falling and rising is thrown away, and neither wiper changes.
- R6: Each commit raises the strobe of the updated channel only, for exactly one system clock, in the same cycle that the new code appears.
- R7: Serial clock and data activity while select is high changes neither wiper and raises no strobe.
- R8: A wiper output changes only in a cycle in which its own strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock, data taken on rising edges |
| sdata | input | 1 | Serial data in |
| wiper0 | output | 8 | Wiper code of channel 0 |
| wiper1 | output | 8 | Wiper code of channel 1 |
| load0 | output | 1 | One-cycle strobe when wiper0 is updated |
| load1 | output | 1 | One-cycle strobe when wiper1 is updated |

## Verification
The bench sends frames of 0, 5, 8, 9, 12 and 15 clock edges. A design that counted frames from the first bit, or that committed short frames, would load the wrong code or change a wiper that must hold. The bench alternates the address and drives the all-zero and all-ones codes, which would expose a swapped address decode or a corrupted neighbour register. It also toggles the clock and data lines while select is high and counts strobe pulses. A design that shifted while idle, or that committed without a falling select, would show a spurious strobe or a changed code.

// File: rtl/spi_wiper_ctrl.sv
module spi_wiper_ctrl #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [CODE_W-1:0] wiper0,
  output logic [CODE_W-1:0] wiper1,
  output logic              load0,
  output logic              load1
);
  localparam int FRAME_W = CODE_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [SYNC_STAGES-1:0] sel_sy, ck_sy, dt_sy;
  logic                   sel_q, ck_q;
  logic [FRAME_W-1:0]     shreg;
  logic [CNT_W-1:0]       cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sy <= '1;
      ck_sy  <= '0;
      dt_sy  <= '0;
      sel_q  <= 1'b1;
      ck_q   <= 1'b0;
    end else begin
      sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_n};
      ck_sy  <= {ck_sy[SYNC_STAGES-2:0], sclk};
      dt_sy  <= {dt_sy[SYNC_STAGES-2:0], sdata};
      sel_q  <= sel_sy[SYNC_STAGES-1];
      ck_q   <= ck_sy[SYNC_STAGES-1];
    end
  end

  wire sel_s    = sel_sy[SYNC_STAGES-1];
  wire ck_rise  = !sel_s && ck_sy[SYNC_STAGES-1] && !ck_q;
  wire sel_fall = !sel_s && sel_q;
  wire sel_rise = sel_s && !sel_q;
  wire full     = (cnt == CNT_W'(FRAME_W));
  wire commit   = sel_rise && full;
  wire addr     = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      if (ck_rise)
        shreg <= {shreg[FRAME_W-2:0], dt_sy[SYNC_STAGES-1]};
      if (sel_fall)
        cnt <= ck_rise ? CNT_W'(1) : '0;
      else if (ck_rise && !full)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper0 <= MID;
      wiper1 <= MID;
      load0  <= 1'b0;
      load1  <= 1'b0;
    end else begin
      load0 <= commit && !addr;
      load1 <= commit && addr;
      if (commit && !addr) wiper0 <= shreg[CODE_W-1:0];
      if (commit && addr)  wiper1 <= shreg[CODE_W-1:0];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load0 && load1)); // R6
  AST_STROBE_SHORT0: assert property (@(posedge clk) disable iff (!rst_n)
    load0 |=> !load0); // R6
  AST_STROBE_SHORT1: assert property (@(posedge clk) disable iff (!rst_n)
    load1 |=> !load1); // R6
  AST_W0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper0 != $past(wiper0)) |-> load0); // R8
  AST_W1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper1 != $past(wiper1)) |-> load1); // R8
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> ($stable(shreg) && $stable(cnt))); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_W)); // R4
endmodule

// File: tb/spi_wiper_ctrl_tb.sv
module spi_wiper_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [7:0] wiper0, wiper1;
  logic load0, load1;
  int checks = 0, errors = 0;
  int n_ld0 = 0, n_ld1 = 0;
  logic [7:0] seen0 = 8'h00, seen1 = 8'h00;
  logic done = 1'b0;

  always #5 clk = ~clk;

  spi_wiper_ctrl dut_i (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
    .sdata(sdata), .wiper0(wiper0), .wiper1(wiper1), .load0(load0), .load1(load1));

  always @(posedge clk) begin
    if (load0) begin n_ld0 <= n_ld0 + 1; seen0 <= wiper0; end
    if (load1) begin n_ld1 <= n_ld1 + 1; seen1 <= wiper1; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input int n, input logic [15:0] w);
    @(negedge clk); sel_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (4) @(negedge clk); sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  // {bits, word}: word sent from bit bits-1 down to bit 0
  localparam logic [20:0] VEC [10] = '{
    {5'd9,  16'h003C}, {5'd9,  16'h01A5}, {5'd9,  16'h00FF}, {5'd9,  16'h0100},
    {5'd12, 16'h0A65}, {5'd15, 16'h7F5A}, {5'd5,  16'h001F}, {5'd8,  16'h00AA},
    {5'd0,  16'h0000}, {5'd9,  16'h0080}};

  initial begin
    logic [7:0] e0, e1;
    int b0, b1;
    repeat (3) @(negedge clk);
    chk("R1 wiper0 reset", wiper0, 8'h80);
    chk("R1 wiper1 reset", wiper1, 8'h80);
    chk("R1 load0 reset", load0, 0);
    chk("R1 load1 reset", load1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e0 = 8'h80; e1 = 8'h80;
    for (int v = 0; v < 10; v++) begin
      int n;
      logic [15:0] w;
      n = int'(VEC[v][20:16]); w = VEC[v][15:0];
      b0 = n_ld0; b1 = n_ld1;
      send(n, w);
      if (n >= 9) begin
        if (w[8]) e1 = w[7:0]; else e0 = w[7:0];
        chk("R6 strobe count ch0", n_ld0 - b0, w[8] ? 0 : 1);
        chk("R6 strobe count ch1", n_ld1 - b1, w[8] ? 1 : 0);
        chk("R6 value with strobe", w[8] ? seen1 : seen0, w[7:0]);
      end else begin
        chk("R5 short frame no strobe", (n_ld0 - b0) + (n_ld1 - b1), 0);
      end
      chk(n > 9 ? "R4 wiper0" : "R2 R3 wiper0", wiper0, e0);
      chk(n > 9 ? "R4 wiper1" : "R2 R3 wiper1", wiper1, e1);
    end
    // R7: serial activity with select high
    b0 = n_ld0; b1 = n_ld1;
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    chk("R7 no strobe while idle", (n_ld0 - b0) + (n_ld1 - b1), 0);
    chk("R7 wiper0 idle", wiper0, e0);
    chk("R7 wiper1 idle", wiper1, e1);
    // R3: write ch1 then check ch0 kept
    send(9, 16'h0133);
    chk("R3 ch0 untouched", wiper0, e0);
    chk("R3 ch1 written", wiper1, 8'h33);
    // R1: reset restores midscale
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 wiper0 after reset", wiper0, 8'h80);
    chk("R1 wiper1 after reset", wiper1, 8'h80);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule